// File: doc/BRIEF.md
# Byte-Port Packet Device Register Block

This block is a memory-mapped register slave that lets a processor exchange packets with a simple network device. Data moves one byte per register access. On receive, bytes arrive on an input byte stream and are held in an internal buffer. When the last byte arrives, the block publishes the packet length and raises an interrupt. Software then drains the packet through a receive data port, and the length counts down on every read.

On transmit, software writes the packet length and then writes exactly that many bytes to a transmit data port. The block forwards those bytes on an output byte stream, marks the final byte as last, clears the length and raises a transmit-done interrupt. The block also has a busy flag, a 64-bit identification value, a read-only interrupt line number, and an interrupt control register. That register combines write-one-to-clear done flags with a self-test interrupt source.

The address space covers 0x40 bytes and uses word-aligned offsets. Only the low byte of each data port carries data.

Top module: `pktdev_regs`

## Requirements
- R1: After reset, `irq_o` is low, `tx_valid_o` is low, `rx_ready_o` is high, and the busy register (0x08) and interrupt control register (0x14) read 0.
- R2: Offset 0x00 reads bits 31:0 and offset 0x04 reads bits 63:32 of the identification parameter. With the default value, the eight ASCII characters of the identification are stored with the first character in the lowest byte. Every other offset in the 0x40 space reads 0, and writes to those offsets are ignored. An unmapped offset is any offset other than 0x00 through 0x20, or any offset not aligned to four bytes.
- R3: When a stream byte with `rx_last_i` high is accepted, the receive count (0x0C) reads the number of bytes in the packet. In the same step, interrupt control bit 1 (receive pending) sets and `irq_o` goes high.
- R4: Each read of the receive data port (0x1C) returns the next packet byte in arrival order in bits 7:0, with the upper bits at 0. Each such read lowers the receive count by one. When the count is 0, a read returns 0 and the count stays at 0.
- R5: While receive-pending is set or the receive count is nonzero, `rx_ready_o` is low and no stream byte is accepted.
- R6: The busy register reads 1 while a packet is partly received. It also reads 1 from the write of a transmit length until the last byte of that packet leaves on the stream. Otherwise it reads 0.
- R7: After a nonzero length N is written to the transmit count (0x10) and N bytes are written to the transmit data port (0x20), the stream emits the low bytes in order, with `tx_last_o` on the Nth byte. Once the Nth byte is taken, the transmit count reads 0 and interrupt control bit 0 (transmit done) is set.
- R8: A write to the transmit count while it is nonzero is ignored. Writes to the transmit data port beyond the programmed length are ignored.
- R9: Writing 1 to bit 0 or bit 1 of interrupt control clears that flag. A 0 in either bit leaves that flag unchanged.
- R10: Writing 1 to bit 31 of interrupt control raises the test interrupt. The first read after that shows bit 31 set, and later reads show it clear. `irq_o` stays high from the test source until a write of 0 to interrupt control.
- R11: `irq_o` is high exactly when transmit-done, receive-pending or the test interrupt is active. Releasing one source leaves the others in effect.
- R12: Interrupt info (0x18) reads the `IRQ_LINE` parameter. Writes to the identification, busy and interrupt info offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset within the 0x40 space |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| rx_valid_i | input | 1 | Receive stream byte valid |
| rx_data_i | input | 8 | Receive stream byte |
| rx_last_i | input | 1 | Receive byte is the last byte of its packet |
| rx_ready_o | output | 1 | Block can take a receive byte |
| tx_valid_o | output | 1 | Transmit stream byte valid |
| tx_data_o | output | 8 | Transmit stream byte |
| tx_last_o | output | 1 | Transmit byte is the last byte of its packet |
| tx_ready_i | input | 1 | Sink takes the transmit byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the receive stream never delivers more bytes in one packet than the receive buffer holds. They also assume that software never has more transmit bytes outstanding than the transmit buffer holds, because a byte pushed into a full buffer is lost. The bench keeps within both limits by using packets of one to three bytes against the default depths. The assertions further assume that a sink holding `tx_ready_i` low sees a stable byte. The bench checks this by writing the whole transmit packet before raising `tx_ready_i`.

// File: rtl/pktdev_pkg.sv
package pktdev_pkg;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 4;

  // word index = byte offset / 4
  localparam logic [WORD_W-1:0] W_ID_LO   = 4'd0;
  localparam logic [WORD_W-1:0] W_ID_HI   = 4'd1;
  localparam logic [WORD_W-1:0] W_BUSY    = 4'd2;
  localparam logic [WORD_W-1:0] W_RXCNT   = 4'd3;
  localparam logic [WORD_W-1:0] W_TXCNT   = 4'd4;
  localparam logic [WORD_W-1:0] W_INTCTL  = 4'd5;
  localparam logic [WORD_W-1:0] W_INTINFO = 4'd6;
  localparam logic [WORD_W-1:0] W_RXDATA  = 4'd7;
  localparam logic [WORD_W-1:0] W_TXDATA  = 4'd8;

  localparam int INT_TX   = 0;
  localparam int INT_RX   = 1;
  localparam int INT_TEST = 31;
endpackage

// File: rtl/pktdev_fifo.sv
module pktdev_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic         empty_o,
  output logic [W-1:0] dout_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == (AW+1)'(DEPTH));
  assign empty_o = (cnt == '0);
  assign dout_o  = mem[rp];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/pktdev_irq.sv
module pktdev_irq
  import pktdev_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_set_i,
  input  logic        rx_set_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ctl_o,
  output logic        rx_pend_o,
  output logic        irq_o
);
  logic tx_done, rx_pend, test_irq, test_vis;
  logic wr_zero;

  assign wr_zero = wr_i & (wdata_i == 32'h0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_done  <= 1'b0;
      rx_pend  <= 1'b0;
      test_irq <= 1'b0;
      test_vis <= 1'b0;
    end else begin
      // set beats clear
      if (tx_set_i)                     tx_done <= 1'b1;
      else if (wr_i && wdata_i[INT_TX]) tx_done <= 1'b0;
      if (rx_set_i)                     rx_pend <= 1'b1;
      else if (wr_i && wdata_i[INT_RX]) rx_pend <= 1'b0;
      // test source: line held until write of zero, view cleared by a read
      if (wr_i && wdata_i[INT_TEST]) begin
        test_irq <= 1'b1;
        test_vis <= 1'b1;
      end else if (wr_zero) begin
        test_irq <= 1'b0;
        test_vis <= 1'b0;
      end else if (rd_i) begin
        test_vis <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl_o           = '0;
    ctl_o[INT_TX]   = tx_done;
    ctl_o[INT_RX]   = rx_pend;
    ctl_o[INT_TEST] = test_vis;
  end

  assign rx_pend_o = rx_pend;
  assign irq_o     = tx_done | rx_pend | test_irq;
endmodule

// File: rtl/pktdev_regs.sv
module pktdev_regs
  import pktdev_pkg::*;
#(
  parameter logic [63:0] ID_VAL   = 64'h3054_454E_5350_494D,
  parameter int          IRQ_LINE = 3,
  parameter int          MAX_LEN  = 65536,
  parameter int          RX_DEPTH = 64,
  parameter int          TX_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic              aligned, rd, wr;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  rx_cnt_q, rx_len_q, tx_cnt_q, tx_left_q;
  logic              in_rx_q, busy, rx_pend;
  logic              rx_fire, rx_full, rx_empty, rx_pop;
  logic [7:0]        rx_head;
  logic              tx_push, tx_full, tx_empty, tx_fire;
  logic [8:0]        tx_head;
  logic              tx_done_set, rx_done_set;
  logic [31:0]       intctl;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign word    = addr_i[ADDR_W-1:2];
  assign rd      = req_i & ~we_i & aligned;
  assign wr      = req_i &  we_i & aligned;

  // receive path
  assign rx_ready_o  = ~rx_pend & (rx_cnt_q == '0) & ~rx_full;
  assign rx_fire     = rx_valid_i & rx_ready_o;
  assign rx_done_set = rx_fire & rx_last_i;
  assign rx_pop      = rd & (word == W_RXDATA) & (rx_cnt_q != '0);

  pktdev_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_buf (
    .clk_i, .rst_ni,
    .push_i(rx_fire), .din_i(rx_data_i), .pop_i(rx_pop),
    .full_o(rx_full), .empty_o(rx_empty), .dout_o(rx_head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cnt_q <= '0;
      rx_len_q <= '0;
      in_rx_q  <= 1'b0;
    end else begin
      if (rx_fire) begin
        if (rx_last_i) begin
          rx_cnt_q <= rx_len_q + CNT_W'(1);
          rx_len_q <= '0;
          in_rx_q  <= 1'b0;
        end else begin
          rx_len_q <= rx_len_q + CNT_W'(1);
          in_rx_q  <= 1'b1;
        end
      end else if (rx_pop) begin
        rx_cnt_q <= rx_cnt_q - CNT_W'(1);
      end
    end
  end

  // transmit path
  assign tx_push     = wr & (word == W_TXDATA) & (tx_left_q != '0) & ~tx_full;
  assign tx_valid_o  = ~tx_empty;
  assign tx_data_o   = tx_head[7:0];
  assign tx_last_o   = tx_head[8];
  assign tx_fire     = tx_valid_o & tx_ready_i;
  assign tx_done_set = tx_fire & tx_last_o;

  pktdev_fifo #(.W(9), .DEPTH(TX_DEPTH)) u_tx_buf (
    .clk_i, .rst_ni,
    .push_i(tx_push), .din_i({tx_left_q == CNT_W'(1), wdata_i[7:0]}),
    .pop_i(tx_fire),
    .full_o(tx_full), .empty_o(tx_empty), .dout_o(tx_head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_cnt_q  <= '0;
      tx_left_q <= '0;
    end else begin
      if (tx_done_set) begin
        tx_cnt_q <= '0;
      end else if (wr && word == W_TXCNT && tx_cnt_q == '0 &&
                   wdata_i[CNT_W-1:0] != '0) begin
        tx_cnt_q  <= wdata_i[CNT_W-1:0];
        tx_left_q <= wdata_i[CNT_W-1:0];
      end
      if (tx_push) tx_left_q <= tx_left_q - CNT_W'(1);
    end
  end

  assign busy = in_rx_q | (tx_cnt_q != '0);

  pktdev_irq u_irq (
    .clk_i, .rst_ni,
    .tx_set_i(tx_done_set), .rx_set_i(rx_done_set),
    .wr_i(wr & (word == W_INTCTL)), .rd_i(rd & (word == W_INTCTL)),
    .wdata_i, .ctl_o(intctl), .rx_pend_o(rx_pend), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (word)
        W_ID_LO:   rdata_o = ID_VAL[31:0];
        W_ID_HI:   rdata_o = ID_VAL[63:32];
        W_BUSY:    rdata_o = {31'b0, busy};
        W_RXCNT:   rdata_o = 32'(rx_cnt_q);
        W_TXCNT:   rdata_o = 32'(tx_cnt_q);
        W_INTCTL:  rdata_o = intctl;
        W_INTINFO: rdata_o = IRQ_LINE;
        W_RXDATA:  rdata_o = {24'b0, (rx_cnt_q != '0) ? rx_head : 8'h00};
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pktdev_regs_chk.sv
module pktdev_regs_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [5:0]       addr_i,
  input logic             rx_valid_i,
  input logic             rx_last_i,
  input logic             rx_ready_o,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic [7:0]       tx_data_o,
  input logic             tx_last_o,
  input logic             irq_o,
  input logic             busy,
  input logic             rx_pend,
  input logic [CNT_W-1:0] rx_cnt_q,
  input logic [CNT_W-1:0] tx_cnt_q
);
  // R5
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pend |-> !rx_ready_o);

  // R3
  rx_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && rx_ready_o && rx_last_i |=> irq_o && rx_pend);

  // R4
  rx_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == 6'h1C && rx_cnt_q == '0 && !rx_pend
    |=> rx_cnt_q == '0);

  // R7
  tx_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o));

  // R7
  tx_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_last_o |=> tx_cnt_q == '0 && irq_o);

  // R6
  tx_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> busy);
endmodule

bind pktdev_regs pktdev_regs_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rx_valid_i(rx_valid_i), .rx_last_i(rx_last_i), .rx_ready_o(rx_ready_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
  .tx_last_o(tx_last_o), .irq_o(irq_o), .busy(busy), .rx_pend(rx_pend),
  .rx_cnt_q(rx_cnt_q), .tx_cnt_q(tx_cnt_q)
);

// File: tb/pktdev_regs_bench.sv
module pktdev_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_last, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  pktdev_regs u_pktdev_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
    .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .irq_o(irq)
  );

  typedef struct packed {
    logic        we;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h00, 32'h0, 32'h5350494D, 1'b0, 4'd2},  // R2 id low
    '{1'b0, 6'h04, 32'h0, 32'h3054454E, 1'b0, 4'd2},  // R2 id high
    '{1'b0, 6'h24, 32'h0, 32'h0,        1'b0, 4'd2},  // R2 unmapped
    '{1'b1, 6'h24, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd2},  // R2
    '{1'b0, 6'h24, 32'h0, 32'h0,        1'b0, 4'd2},  // R2
    '{1'b0, 6'h15, 32'h0, 32'h0,        1'b0, 4'd2},  // R2 misaligned
    '{1'b0, 6'h18, 32'h0, 32'h3,        1'b0, 4'd12}, // R12
    '{1'b1, 6'h18, 32'h55, 32'h0,       1'b0, 4'd12}, // R12
    '{1'b0, 6'h18, 32'h0, 32'h3,        1'b0, 4'd12}, // R12
    '{1'b1, 6'h00, 32'h0, 32'h0,        1'b0, 4'd12}, // R12
    '{1'b0, 6'h00, 32'h0, 32'h5350494D, 1'b0, 4'd12}, // R12
    '{1'b0, 6'h08, 32'h0, 32'h0,        1'b0, 4'd1},  // R1 busy
    '{1'b0, 6'h14, 32'h0, 32'h0,        1'b0, 4'd1},  // R1 intctl
    '{1'b1, 6'h14, 32'h80000000, 32'h0, 1'b1, 4'd10}, // R10 raise
    '{1'b0, 6'h14, 32'h0, 32'h80000000, 1'b1, 4'd10}, // R10 seen once
    '{1'b0, 6'h14, 32'h0, 32'h0,        1'b1, 4'd10}, // R10 cleared by read
    '{1'b1, 6'h14, 32'h0, 32'h0,        1'b0, 4'd10}, // R10 release
    '{1'b0, 6'h14, 32'h0, 32'h0,        1'b0, 4'd10}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [5:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1 r = rdata;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] r;
    acc(1'b1, a, d, r);
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] r;
    acc(1'b0, a, 32'h0, r);
    chk(tag, r, exp);
  endtask

  task automatic rx_byte(input logic [7:0] d, input logic l);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_last = l;
    @(posedge clk);
    #1 rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state at the ports
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].we, VEC[i].addr, VEC[i].wdata, r);
      if (!VEC[i].we) chk($sformatf("R%0d vec%0d rdata", VEC[i].req, i), r, VEC[i].exp_rd);
      chk($sformatf("R%0d vec%0d irq", VEC[i].req, i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
    end

    // receive of three bytes
    rx_byte(8'hA1, 1'b0);
    rd_chk("R6 busy mid-rx", 6'h08, 32'h1);
    rx_byte(8'hB2, 1'b0);
    rx_byte(8'hC3, 1'b1);
    chk("R3 irq", {31'b0, irq}, 32'h1);
    rd_chk("R3 rx count", 6'h0C, 32'd3);
    rd_chk("R3 intctl", 6'h14, 32'h2);
    rd_chk("R6 busy after rx", 6'h08, 32'h0);
    chk("R5 ready low", {31'b0, rx_ready}, 32'h0);
    rx_byte(8'hEE, 1'b1);  // must not be taken
    rd_chk("R5 count held", 6'h0C, 32'd3);
    rd_chk("R4 byte0", 6'h1C, 32'hA1);
    rd_chk("R4 count2", 6'h0C, 32'd2);
    rd_chk("R4 byte1", 6'h1C, 32'hB2);
    rd_chk("R4 byte2", 6'h1C, 32'hC3);
    rd_chk("R4 count0", 6'h0C, 32'd0);
    rd_chk("R4 empty read", 6'h1C, 32'h0);
    rd_chk("R4 no underflow", 6'h0C, 32'd0);
    chk("R5 ready low while pending", {31'b0, rx_ready}, 32'h0);
    wr(6'h14, 32'h1);
    rd_chk("R9 zero bit leaves rx flag", 6'h14, 32'h2);
    wr(6'h14, 32'h80000000);
    wr(6'h14, 32'h0);
    chk("R11 rx source keeps irq", {31'b0, irq}, 32'h1);
    wr(6'h14, 32'h2);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    rd_chk("R9 intctl", 6'h14, 32'h0);
    chk("R5 ready again", {31'b0, rx_ready}, 32'h1);

    // single-byte packet
    rx_byte(8'h5A, 1'b1);
    rd_chk("R3 one-byte count", 6'h0C, 32'd1);
    rd_chk("R4 one-byte data", 6'h1C, 32'h5A);
    wr(6'h14, 32'h2);

    // transmit of three bytes, sink stalled
    wr(6'h10, 32'd3);
    rd_chk("R6 busy tx", 6'h08, 32'h1);
    wr(6'h10, 32'd9);
    rd_chk("R8 count kept", 6'h10, 32'd3);
    wr(6'h20, 32'h111);
    wr(6'h20, 32'h22);
    wr(6'h20, 32'h33);
    wr(6'h20, 32'h44);
    tx_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk($sformatf("R7 tx valid %0d", i), {31'b0, tx_valid}, 32'h1);
      chk($sformatf("R7 tx byte %0d", i), {24'b0, tx_data}, 32'h11 * (i + 1));
      chk($sformatf("R7 tx last %0d", i), {31'b0, tx_last}, {31'b0, i == 2});
    end
    @(negedge clk);
    #1 chk("R8 extra byte dropped", {31'b0, tx_valid}, 32'h0);
    rd_chk("R7 count cleared", 6'h10, 32'd0);
    rd_chk("R7 intctl", 6'h14, 32'h1);
    chk("R11 tx irq", {31'b0, irq}, 32'h1);
    rd_chk("R6 busy idle", 6'h08, 32'h0);
    wr(6'h14, 32'h1);
    chk("R9 tx cleared", {31'b0, irq}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule